// File: doc/BRIEF.md
# SMBus configuration register slave

This block is a two-wire serial slave that gives a host access to a small bank of configuration bytes, for example output-buffer enables of a clock generator. The host reaches it over an SCL/SDA pair. Both lines are oversampled by the faster system clock, and the slave pulls SDA low through an open-drain enable. The whole bank is presented as a parallel output vector, so the surrounding logic reads its configuration straight from the flops. Every byte comes up at a fixed default after reset, so the chip runs correctly even if the host never touches the bus.

The command byte that follows the write address picks the access type. With its top bit set, the access is to one register whose offset is held in the low bits. With the top bit clear, the access is a block transfer that starts at register 0 and walks upwards. A block write normally carries a byte count ahead of its data. Setting a mode bit in register 0 removes that count for hosts that speak plain I2C. A block read always returns the bank size as a count before the data bytes.

Top module: `smbs_cfg_slave`

## Requirements
- R1: The slave acknowledges (holds SDA low through the ninth clock) an address byte whose upper seven bits equal 1101001, that is 0xD2 for write and 0xD3 for read. It acknowledges every byte it accepts after that.
- R2: After any other address byte the slave does not acknowledge, and all bytes up to the next start condition leave the bank unchanged.
- R3: A command byte with bit 7 = 1 selects a single-register access whose offset is bits 6:0 modulo 8. The data byte of a byte write lands in that register.
- R4: A byte read (write address, command, repeated start, read address) returns the addressed register MSB first.
- R5: When bank bit 7 (bit 7 of register 0) is 0, a block write (command bit 7 = 0) treats the byte after the command as a count, discards it, and stores the following bytes into registers 0, 1, 2 … in order.
- R6: When bank bit 7 is 1, a block write has no count phase: the first byte after the command goes into register 0.
- R7: A block read returns the value 8 first, then registers 0, 1, 2 … MSB first. It continues while the host acknowledges and releases SDA once the host sends NOT-acknowledge.
- R8: The register index of block transfers advances past register 7 to register 0, on both writes and reads.
- R9: After reset the bank output equals 0xFFEEDDCCBBAA550E, with register i at bits 8i+7:8i.
- R10: The slave changes its SDA drive only while SCL is low. A stop condition releases SDA and returns the slave to idle.
- R11: A block write may stop after any complete byte. Registers past the last byte received keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| bank_o | output | 64 | Parallel image of the 8 configuration registers |

## Verification
The case where two functions share one cycle comes at the end of the bank. The same evaluation cycle commits the last register's write and wraps the index to 0, and in another case a block read loads register 7 and wraps the pointer. The bench provokes this with nine-byte block writes and a nine-byte block read. It judges the result by whether the ninth byte lands in, or comes back from, register 0 while register 7 holds the eighth byte. A second overlap comes from a block write in the count-free mode that overwrites register 0, which holds the mode bit itself. The bench checks that the rewritten mode takes effect only from the next transaction on.

// File: rtl/smbs_pkg.sv
// Shared types of the serial configuration slave.
// Assumes: included before every other file of the block.
package smbs_pkg;
    // Bus phase the slave is in.
    typedef enum logic [2:0] {S_IDLE, S_RX, S_SACK, S_TX, S_MACK} bus_state_t;
    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {K_ADDR, K_CMD, K_CNT, K_DATA} rx_kind_t;
endpackage

// File: rtl/smbs_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and reports
// SCL edges plus start and stop conditions, one cycle each.
// Assumes: clk is several times faster than SCL; lines idle high.
module smbs_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
    logic scl_d, sda_d;

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_ff[SYNC_STAGES-1];
            sda_d  <= sda_ff[SYNC_STAGES-1];
        end
    end

    assign scl_o      = scl_ff[SYNC_STAGES-1];
    assign sda_o      = sda_ff[SYNC_STAGES-1];
    assign scl_rise_o = scl_o & ~scl_d;
    assign scl_fall_o = ~scl_o & scl_d;
    assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
    assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/smbs_regbank.sv
// Bank of configuration bytes with reset defaults and one write port.
// Assumes: at most one write per cycle; wr_idx is in range.
module smbs_regbank #(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3,
    parameter logic [NUM_REGS*8-1:0] DEFAULT_IMG = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] bank_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] val;
        // One configuration byte: default at reset, else written when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val <= DEFAULT_IMG[g*8 +: 8];
            else if (wr_en && wr_idx == IDX_W'(g))
                val <= wr_data;
        end
        assign bank_o[g*8 +: 8] = val;
    end

    // R9: first cycle out of reset shows the default image.
    assert_reset_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> bank_o == DEFAULT_IMG);
endmodule

// File: rtl/smbs_cfg_slave.sv
// Two-wire serial slave giving byte and block access to a configuration
// bank. Receives on SCL rise, drives SDA after SCL fall, open drain.
// Assumes: no clock stretching, single master, NUM_REGS a power of two.
module smbs_cfg_slave
    import smbs_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h69,
    parameter int NUM_REGS = 8,
    parameter logic [NUM_REGS*8-1:0] DEFAULT_IMG = 64'hFFEE_DDCC_BBAA_550E,
    parameter int PLAIN_BIT = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] bank_o
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam logic [7:0] COUNT_VAL = 8'(NUM_REGS);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    bus_state_t state;
    rx_kind_t   kind, next_kind;
    logic       next_tx, blk_mode, cnt_pend;
    logic [3:0] bit_cnt;
    logic [7:0] rx_sh, tx_sh, rd_byte, wr_data;
    logic [IDX_W-1:0] idx, wr_idx;
    logic       wr_en, plain_mode;

    smbs_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
    );

    smbs_regbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .DEFAULT_IMG(DEFAULT_IMG)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .bank_o(bank_o)
    );

    assign rd_byte    = bank_o[32'(idx)*8 +: 8];
    assign plain_mode = bank_o[PLAIN_BIT];

    // Bus protocol sequencer: byte reception, acknowledges, transmission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            kind      <= K_ADDR;
            next_kind <= K_ADDR;
            next_tx   <= 1'b0;
            blk_mode  <= 1'b0;
            cnt_pend  <= 1'b0;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            idx       <= '0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= S_RX;
                kind    <= K_ADDR;
                bit_cnt <= '0;
            end else if (stop_det) begin
                state <= S_IDLE;
            end else begin
                case (state)
                    S_RX: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            state   <= S_SACK;
                            next_tx <= 1'b0;
                            case (kind)
                                K_ADDR: begin
                                    if (rx_sh[7:1] == SLAVE_ADDR) begin
                                        next_tx   <= rx_sh[0];
                                        next_kind <= K_CMD;
                                        cnt_pend  <= rx_sh[0] & blk_mode;
                                    end else begin
                                        state <= S_IDLE;
                                    end
                                end
                                K_CMD: begin
                                    blk_mode  <= ~rx_sh[7];
                                    idx       <= rx_sh[7] ? rx_sh[IDX_W-1:0] : '0;
                                    next_kind <= (!rx_sh[7] && !plain_mode) ? K_CNT : K_DATA;
                                end
                                K_CNT:   next_kind <= K_DATA;
                                default: begin
                                    wr_en     <= 1'b1;
                                    wr_idx    <= idx;
                                    wr_data   <= rx_sh;
                                    idx       <= idx + 1'b1;
                                    next_kind <= K_DATA;
                                end
                            endcase
                        end
                    end
                    S_SACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (next_tx) begin
                                state <= S_TX;
                                if (cnt_pend) begin
                                    tx_sh    <= COUNT_VAL;
                                    cnt_pend <= 1'b0;
                                end else begin
                                    tx_sh <= rd_byte;
                                    idx   <= idx + 1'b1;
                                end
                            end else begin
                                state <= S_RX;
                                kind  <= next_kind;
                            end
                        end
                    end
                    S_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                state <= S_MACK;
                            end else begin
                                tx_sh   <= {tx_sh[6:0], 1'b0};
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    S_MACK: begin
                        if (scl_rise && sda_s) begin
                            state <= S_IDLE;
                        end else if (scl_fall) begin
                            state   <= S_TX;
                            bit_cnt <= '0;
                            if (cnt_pend) begin
                                tx_sh    <= COUNT_VAL;
                                cnt_pend <= 1'b0;
                            end else begin
                                tx_sh <= rd_byte;
                                idx   <= idx + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Open-drain drive: acknowledge slot or a zero data bit.
    always_comb begin
        sda_oe_o = (state == S_SACK) || (state == S_TX && !tx_sh[7]);
    end

    // R10: SDA drive only moves while the synchronized SCL is low.
    assert_sda_moves_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);
    // R10: a stop returns the slave to idle with SDA released.
    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && !start_det |=> state == S_IDLE && !sda_oe_o);
    // R1: a start always re-arms address reception.
    assert_start_rearm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == S_RX && kind == K_ADDR && bit_cnt == 4'd0);
    // R3: register writes commit only while SCL is low.
    assert_write_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !scl_s);
endmodule

// File: tb/smbs_cfg_slave_tb.sv
module smbs_cfg_slave_tb;
    localparam int Q = 10;
    localparam logic [63:0] DEF = 64'hFFEE_DDCC_BBAA_550E;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, scl = 1'b1, msda = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [63:0] bank;
    int n_chk = 0, n_fail = 0, viol = 0;
    logic prev_oe = 1'b0;
    logic [7:0] exp_b [8];

    assign sda_line = msda & ~sda_oe;

    smbs_cfg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .bank_o(bank)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_img();
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[i*8 +: 8] = exp_b[i];
        return r;
    endfunction

    // R10 monitor: slave drive must not move while the bench holds SCL high.
    always @(negedge clk) begin
        if (rst_n && scl && sda_oe !== prev_oe) viol++;
        prev_oe = sda_oe;
    end

    task automatic bus_start();
        if (!scl) begin
            msda = 1'b1; tick(Q/2); scl = 1'b1; tick(Q/2);
        end
        msda = 1'b0; tick(Q/2); scl = 1'b0; tick(Q/2);
    endtask

    task automatic bus_stop();
        msda = 1'b0; tick(Q/2); scl = 1'b1; tick(Q/2); msda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            msda = b[i]; tick(Q/2); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q/2);
        end
        msda = 1'b1; tick(Q/2); scl = 1'b1; tick(Q/2);
        ack = !sda_line;
        tick(Q/2); scl = 1'b0; tick(Q/2);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        msda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q/2); scl = 1'b1; tick(Q/2); b[i] = sda_line; tick(Q/2); scl = 1'b0; tick(Q/2);
        end
        msda = nack; tick(Q/2); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q/2);
    endtask

    task automatic byte_write(input int off, input logic [7:0] d);
        logic a0, a1, a2;
        bus_start(); send_byte(8'hD2, a0); send_byte(8'h80 | 8'(off), a1); send_byte(d, a2); bus_stop();
        check("R3 byte write acks", {a0, a1, a2}, 3'b111);
        exp_b[off % 8] = d;
        check("R3 byte write bank", bank, exp_img());
    endtask

    task automatic byte_read(input int off, output logic [7:0] d);
        logic a0, a1, a2;
        bus_start(); send_byte(8'hD2, a0); send_byte(8'h80 | 8'(off), a1);
        bus_start(); send_byte(8'hD3, a2); recv_byte(1'b1, d); bus_stop();
        check("R1 read address acks", {a0, a1, a2}, 3'b111);
    endtask

    initial begin
        tick(190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic a, a1, a2;
        logic [7:0] d;
        for (int i = 0; i < 8; i++) exp_b[i] = DEF[i*8 +: 8];
        tick(5); rst_n = 1'b1; tick(2);
        check("R9 reset defaults", bank, DEF);
        check("R10 released after reset", {63'd0, sda_oe}, 64'd0);

        // R1/R2: sweep all write addresses, only 1101001 acknowledged.
        for (int ad = 0; ad < 128; ad++) begin
            bus_start(); send_byte({7'(ad), 1'b0}, a); bus_stop();
            check(ad == 'h69 ? "R1 address ack" : "R2 address no ack", {63'd0, a}, {63'd0, ad == 'h69});
        end
        check("R2 bank untouched by sweep", bank, exp_img());

        // R2: foreign address followed by command and data is ignored.
        bus_start(); send_byte(8'h52, a); send_byte(8'h83, a1); send_byte(8'hAA, a2); bus_stop();
        check("R2 foreign write no acks", {a, a1, a2}, 3'b000);
        check("R2 foreign write bank", bank, exp_img());

        // R3: byte write every offset with computed data (reg0 keeps mode bit 0).
        for (int off = 0; off < 8; off++)
            byte_write(off, 8'((off * 37 + 5) & (off == 0 ? 'h7F : 'hFF)));
        // R3: offset 13 lands in register 5.
        byte_write(13, 8'hC9);

        // R4: byte read every offset.
        for (int off = 0; off < 8; off++) begin
            byte_read(off, d);
            check("R4 byte read", {56'd0, d}, {56'd0, exp_b[off]});
        end
        byte_read(8 + 2, d);
        check("R3 read offset modulo", {56'd0, d}, {56'd0, exp_b[2]});

        // R5/R11: block write with count, stop after three data bytes.
        bus_start(); send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'd3, a);
        for (int k = 0; k < 3; k++) begin
            send_byte(8'h12 + 8'(k * 34), a1);
            exp_b[k] = 8'h12 + 8'(k * 34);
        end
        bus_stop();
        check("R5 block write with count", bank, exp_img());
        check("R11 trailing registers kept", {40'd0, bank[63:24]}, {40'd0, exp_img() >> 24});

        // R8: nine-byte block write wraps into register 0.
        bus_start(); send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'd9, a);
        for (int k = 0; k < 9; k++) begin
            send_byte(8'h40 + 8'(k), a1);
            exp_b[k % 8] = 8'h40 + 8'(k);
        end
        bus_stop();
        check("R8 write wrap", bank, exp_img());

        // R7/R8: block read returns count, all registers, then wraps.
        bus_start(); send_byte(8'hD2, a); send_byte(8'h00, a1);
        bus_start(); send_byte(8'hD3, a2);
        check("R7 block read acks", {a, a1, a2}, 3'b111);
        recv_byte(1'b0, d);
        check("R7 block read count", {56'd0, d}, 64'd8);
        for (int k = 0; k < 9; k++) begin
            recv_byte(k == 8, d);
            check(k == 8 ? "R8 read wrap" : "R7 block read data", {56'd0, d}, {56'd0, exp_b[k % 8]});
        end
        bus_stop();
        check("R10 released after stop", {63'd0, sda_oe}, 64'd0);

        // R6: set the count-free mode, then block write without count.
        byte_write(0, 8'h80);
        bus_start(); send_byte(8'hD2, a); send_byte(8'h00, a);
        send_byte(8'h81, a1); send_byte(8'h11, a2); bus_stop();
        exp_b[0] = 8'h81; exp_b[1] = 8'h11;
        check("R6 no count phase", bank, exp_img());
        // R6: clearing the mode bit inside a count-free block write.
        bus_start(); send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h05, a); bus_stop();
        exp_b[0] = 8'h05;
        check("R6 mode cleared", bank, exp_img());
        // R5: count phase is back.
        bus_start(); send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h01, a);
        send_byte(8'h27, a); bus_stop();
        exp_b[0] = 8'h27;
        check("R5 count restored", bank, exp_img());

        check("R10 drive only while SCL low", 64'(viol), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule